// File: doc/BRIEF.md
# Two-Plane Mask Cursor Overlay

This block lays a 64x64 pointer image over the pixel stream of a display pipeline. Each pixel of the image has two bits, one in a mask plane and one in an invert plane. The screen pixel is ANDed with the mask bit spread across the whole pixel and then XORed with the invert bit spread the same way. A mask bit of one with an invert bit of zero leaves the screen pixel as it was, so that cursor pixel is transparent. The other combinations give black, white or an inverted screen pixel.

Software sets four registers: an enable, the left column, the top line and the image base in video memory. The image base is forced down to a 1024-byte boundary. The image stores one line of the cursor in 16 consecutive bytes. The first 8 bytes are the mask plane and the last 8 bytes are the invert plane. Within each byte, bit 7 is the leftmost pixel.

A pulse at the start of horizontal blanking starts a 16-byte burst of single-byte reads. The burst fetches the cursor line that the next scan line will need. During active video, the beam position is compared with the cursor window and the buffered line is applied to the incoming pixel. The result leaves through one output register.

Top module: `cursor_overlay`

## Requirements
- R1: After a synchronous reset, `pix_out` is 0 and `mem_rd_en` is 0. The enable is off and the base, column and top line are 0.
- R2: While the enable (bit 0 of a write with `reg_sel`=0) is 0, a blanking pulse starts no memory reads, and `pix_out` equals `pix_in` of the previous cycle.
- R3: A burst starts in the cycle after the blanking pulse. It issues 16 reads on 16 consecutive cycles. The first address is the aligned base plus 16 times the image line, and each later address is one higher. The base is written with `reg_sel`=3, and its bits 9:0 are taken as zero.
- R4: At a blanking pulse with beam line Y, the image line is (Y+1) minus the top line (`reg_sel`=2). A burst runs only when the enable is set and that image line lies in 0..63. Otherwise no read is issued.
- R5: Inside the window, take image column c and let m and v be its mask and invert bits. `pix_out` is then (`pix_in` AND m repeated over all bits) XOR v repeated over all bits. Bit m is bit 7-(c mod 8) of line byte c/8, and bit v is the same bit of line byte 8+c/8.
- R6: A pixel is inside the window when the enable is set, `beam_active` is 1, the last blanking fetch ran, and column X satisfies left <= X < left+64. The left column is written with `reg_sel`=1. Any pixel outside the window passes through unchanged.
- R7: `mem_rd_data` is taken one cycle after the read it answers. `pix_out` follows its `pix_in` and beam position by exactly one clock.
- R8: If the blanking pulse before a line started no burst, that line shows no cursor, even though the line buffer still holds older image data.
- R9: The four mask/invert combinations give these results: 1/0 leaves the pixel unchanged, 1/1 inverts it, 0/1 gives all ones and 0/0 gives all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 enable, 1 left column, 2 top line, 3 image base |
| reg_wdata | input | REG_W | Register write data |
| mem_rd_en | output | 1 | Video memory byte read request |
| mem_rd_addr | output | ADDR_W | Video memory byte address |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| beam_x | input | COORD_W | Current beam column |
| beam_y | input | COORD_W | Current beam line |
| beam_active | input | 1 | High during visible pixels |
| hblank_start | input | 1 | One-cycle pulse at the start of horizontal blanking |
| pix_in | input | PIX_W | Screen pixel |
| pix_out | output | PIX_W | Composited pixel |

## Verification
A wrong line index or a wrong base appears on `mem_rd_addr` at the first read of the burst, which is the cycle after the blanking pulse. A miscounted burst shows up at the end of that burst as too few or too many requests. A mask byte stored in the wrong slot, or a reversed bit order, does not show up until the next visible line. It then appears on `pix_out` one clock after the affected column. Every mask/invert combination is placed at a known column, so a swapped plane is seen as a specific wrong value. A stale line-valid flag shows up as a cursor drawn on a line whose blanking started no burst.

// File: rtl/cursor_pkg.sv
`timescale 1ns/1ps
// Shared constants and register select codes for the cursor overlay.
// Assumes a fixed 64x64 image, two planes, 16 bytes per line.
package cursor_pkg;
    localparam int CUR_SIZE    = 64;
    localparam int LINE_BYTES  = 16;
    localparam int PLANE_BYTES = 8;
    localparam int ALIGN_BITS  = 10;   // 1024-byte image alignment
    localparam int IDX_W       = $clog2(CUR_SIZE);
    localparam int BYTE_IDX_W  = $clog2(LINE_BYTES);

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_LEFT   = 2'd1,
        SEL_TOP    = 2'd2,
        SEL_BASE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cursor_regs.sv
`timescale 1ns/1ps
// Holds the enable, left column, top line and image base of the cursor.
// Assumes REG_W >= ADDR_W and REG_W >= COORD_W; base bits below the
// 1024-byte boundary are dropped on write.
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int REG_W   = 32,
    parameter int COORD_W = 12,
    parameter int ADDR_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic               en,
    output logic [COORD_W-1:0] left,
    output logic [COORD_W-1:0] top,
    output logic [ADDR_W-1:0]  base
);
    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

    // Register update on a write strobe, decoded by select code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            left <= '0;
            top  <= '0;
            base <= '0;
        end else if (reg_we) begin
            case (reg_sel_e'(reg_sel))
                SEL_ENABLE: en   <= reg_wdata[0];
                SEL_LEFT:   left <= reg_wdata[COORD_W-1:0];
                SEL_TOP:    top  <= reg_wdata[COORD_W-1:0];
                SEL_BASE:   base <= {reg_wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                default:    en   <= en;
            endcase
        end
    end
endmodule

// File: rtl/cursor_fetch.sv
`timescale 1ns/1ps
// Fetches the next scan line's cursor bytes during horizontal blanking
// and stores them in a mask buffer and an invert buffer.
// Assumes the memory answers each read exactly one cycle later and that
// blanking lasts at least 18 cycles. Bit 63 of each buffer is column 0.
module cursor_fetch
    import cursor_pkg::*;
#(
    parameter int COORD_W = 12,
    parameter int ADDR_W  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [COORD_W-1:0]  top,
    input  logic [ADDR_W-1:0]   base,
    input  logic [COORD_W-1:0]  beam_y,
    input  logic                hblank_start,
    output logic                mem_rd_en,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic [7:0]          mem_rd_data,
    output logic [CUR_SIZE-1:0] mask_line,
    output logic [CUR_SIZE-1:0] inv_line,
    output logic                line_valid
);
    logic [COORD_W-1:0]    next_y;
    logic [COORD_W-1:0]    rel;
    logic                  hit;
    logic                  busy;
    logic [BYTE_IDX_W-1:0] cnt;
    logic [ADDR_W-1:0]     line_base;
    logic                  cap_v;
    logic [BYTE_IDX_W-1:0] cap_idx;
    logic [4:0]            burst_len;

    // Decide whether the next scan line falls inside the image.
    always_comb begin
        next_y = beam_y + 1'b1;
        rel    = next_y - top;
        hit    = en && (next_y >= top) && (rel < COORD_W'(CUR_SIZE));
    end

    assign mem_rd_en   = busy;
    assign mem_rd_addr = line_base + ADDR_W'(cnt);

    // Burst sequencer: one read per cycle for the 16 line bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cnt        <= '0;
            line_base  <= '0;
            line_valid <= 1'b0;
        end else if (!busy && hblank_start) begin
            line_valid <= hit;
            busy       <= hit;
            cnt        <= '0;
            line_base  <= base + (ADDR_W'(rel[IDX_W-1:0]) << BYTE_IDX_W);
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == BYTE_IDX_W'(LINE_BYTES - 1)) busy <= 1'b0;
        end
    end

    // Track which returned byte arrives in the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v   <= 1'b0;
            cap_idx <= '0;
        end else begin
            cap_v   <= busy;
            cap_idx <= cnt;
        end
    end

    // Steer each returned byte into its plane buffer, leftmost pixel high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_line <= '0;
            inv_line  <= '0;
        end else if (cap_v) begin
            if (cap_idx < BYTE_IDX_W'(PLANE_BYTES))
                mask_line[8*(PLANE_BYTES-1-int'(cap_idx[2:0])) +: 8] <= mem_rd_data;
            else
                inv_line[8*(PLANE_BYTES-1-int'(cap_idx[2:0])) +: 8] <= mem_rd_data;
        end
    end

    // Checker count of consecutive read cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         burst_len <= '0;
        else if (mem_rd_en) burst_len <= burst_len + 1'b1;
        else                burst_len <= '0;
    end

    AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |-> mem_rd_addr[BYTE_IDX_W-1:0] == '0); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> mem_rd_addr == $past(mem_rd_addr) + 1'b1); // R3
    AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_en) |-> burst_len == 5'(LINE_BYTES)); // R3
    AST_NO_FETCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |-> $past(en)); // R2
endmodule

// File: rtl/cursor_blend.sv
`timescale 1ns/1ps
// Combines the buffered cursor line with the screen pixel: AND with the
// spread mask bit, then XOR with the spread invert bit. Output registered.
// Assumes the line buffers hold the current scan line when line_valid is set.
module cursor_blend
    import cursor_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int COORD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [COORD_W-1:0]  left,
    input  logic [COORD_W-1:0]  beam_x,
    input  logic                beam_active,
    input  logic                line_valid,
    input  logic [CUR_SIZE-1:0] mask_line,
    input  logic [CUR_SIZE-1:0] inv_line,
    input  logic [PIX_W-1:0]    pix_in,
    output logic [PIX_W-1:0]    pix_out
);
    logic [COORD_W-1:0] col;
    logic [IDX_W-1:0]   idx;
    logic               in_win;
    logic               m_bit;
    logic               v_bit;

    // Window test and per-column plane bit selection.
    always_comb begin
        col    = beam_x - left;
        idx    = col[IDX_W-1:0];
        in_win = en && beam_active && line_valid &&
                 (beam_x >= left) && (col < COORD_W'(CUR_SIZE));
        m_bit  = mask_line[CUR_SIZE-1-int'(idx)];
        v_bit  = inv_line[CUR_SIZE-1-int'(idx)];
    end

    // Output register: composite inside the window, pass-through outside.
    always_ff @(posedge clk) begin
        if (!rst_n)      pix_out <= '0;
        else if (in_win) pix_out <= (pix_in & {PIX_W{m_bit}}) ^ {PIX_W{v_bit}};
        else             pix_out <= pix_in;
    end

    AST_PASS_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |=> pix_out == $past(pix_in)); // R6
    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && m_bit && !v_bit) |=> pix_out == $past(pix_in)); // R9
    AST_FORCED_WHITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && !m_bit && v_bit) |=> pix_out == '1); // R9
endmodule

// File: rtl/cursor_overlay.sv
`timescale 1ns/1ps
// Top of the two-plane cursor overlay: register block, blanking-time line
// fetch and pixel compositor. Assumes a single pixel clock domain.
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int COORD_W = 12,
    parameter int ADDR_W  = 24,
    parameter int REG_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic [7:0]         mem_rd_data,
    input  logic [COORD_W-1:0] beam_x,
    input  logic [COORD_W-1:0] beam_y,
    input  logic               beam_active,
    input  logic               hblank_start,
    input  logic [PIX_W-1:0]   pix_in,
    output logic [PIX_W-1:0]   pix_out
);
    logic                en;
    logic [COORD_W-1:0]  left;
    logic [COORD_W-1:0]  top;
    logic [ADDR_W-1:0]   base;
    logic [CUR_SIZE-1:0] mask_line;
    logic [CUR_SIZE-1:0] inv_line;
    logic                line_valid;

    cursor_regs #(.REG_W(REG_W), .COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .en(en), .left(left), .top(top), .base(base)
    );

    cursor_fetch #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .en(en), .top(top), .base(base),
        .beam_y(beam_y), .hblank_start(hblank_start),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mask_line(mask_line), .inv_line(inv_line), .line_valid(line_valid)
    );

    cursor_blend #(.PIX_W(PIX_W), .COORD_W(COORD_W)) u_blend (
        .clk(clk), .rst_n(rst_n), .en(en), .left(left), .beam_x(beam_x),
        .beam_active(beam_active), .line_valid(line_valid),
        .mask_line(mask_line), .inv_line(inv_line),
        .pix_in(pix_in), .pix_out(pix_out)
    );

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mem_rd_en && pix_out == '0)); // R1
endmodule

// File: tb/cursor_overlay_tb.sv
`timescale 1ns/1ps
module cursor_overlay_tb;
    localparam int PIX_W = 8, COORD_W = 12, ADDR_W = 24, REG_W = 32;
    localparam int LEFT = 100, TOP = 40;
    localparam logic [ADDR_W-1:0] BASE_AL = 24'h012000;
    // stimulus: {beam column, screen pixel}
    localparam logic [19:0] VEC [0:11] = '{
        {12'd99, 8'h5A}, {12'd100, 8'h3C}, {12'd101, 8'h3C}, {12'd102, 8'h3C},
        {12'd103, 8'h3C}, {12'd107, 8'h81}, {12'd108, 8'hF0}, {12'd131, 8'h55},
        {12'd163, 8'h77}, {12'd164, 8'h77}, {12'd250, 8'h12}, {12'd0, 8'hEE}};

    logic clk = 0, rst_n = 0;
    logic reg_we = 0;
    logic [1:0] reg_sel = 0;
    logic [REG_W-1:0] reg_wdata = 0;
    logic mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [7:0] mem_rd_data = 0;
    logic [COORD_W-1:0] beam_x = 0, beam_y = 0;
    logic beam_active = 0, hblank_start = 0;
    logic [PIX_W-1:0] pix_in = 0;
    logic [PIX_W-1:0] pix_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] img [0:1023];
    int rd_count = 0, addr_err = 0;
    logic [ADDR_W-1:0] first_addr = 0, prev_addr = 0;

    always #2.5 clk = ~clk;

    cursor_overlay #(.PIX_W(PIX_W), .COORD_W(COORD_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .beam_x(beam_x), .beam_y(beam_y), .beam_active(beam_active),
        .hblank_start(hblank_start), .pix_in(pix_in), .pix_out(pix_out));

    // memory model with one-cycle read latency, plus burst monitor
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= img[mem_rd_addr[9:0]];
            if (rd_count == 0) first_addr <= mem_rd_addr;
            else if (mem_rd_addr != prev_addr + 1) addr_err <= addr_err + 1;
            if (mem_rd_addr[ADDR_W-1:10] != BASE_AL[ADDR_W-1:10]) addr_err <= addr_err + 1;
            prev_addr <= mem_rd_addr;
            rd_count <= rd_count + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic blank(input int y);
        @(negedge clk);
        beam_active = 0; beam_y = COORD_W'(y); hblank_start = 1;
        rd_count = 0; addr_err = 0;
        @(negedge clk); hblank_start = 0;
        repeat (22) @(negedge clk);
        beam_y = COORD_W'(y + 1);
    endtask

    // drive one visible pixel, return output one clock later
    task automatic pix(input int x, input logic [7:0] p, output logic [7:0] o);
        @(negedge clk); beam_active = 1; beam_x = COORD_W'(x); pix_in = p;
        @(negedge clk); o = pix_out;
    endtask

    function automatic logic [7:0] model(input int row, input int x, input logic [7:0] p);
        int c;
        logic m, v;
        if (x < LEFT || x >= LEFT + 64) return p;
        c = x - LEFT;
        m = img[row*16 + c/8][7 - c%8];
        v = img[row*16 + 8 + c/8][7 - c%8];
        return (p & {8{m}}) ^ {8{v}};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] o;
        for (int i = 0; i < 1024; i++) img[i] = 8'(i * 37) ^ 8'(i >> 4);
        img[160] = 8'hCC; // line 10 mask byte 0
        img[168] = 8'hAA; // line 10 invert byte 0
        repeat (3) @(negedge clk);
        chk(pix_out == 0 && mem_rd_en == 0, "R1 reset outputs", {pix_out, 7'd0, mem_rd_en}, 0);
        rst_n = 1;
        wr(2'd1, LEFT); wr(2'd2, TOP); wr(2'd3, 32'h00012345);

        // R2: disabled, no fetch, pass-through
        blank(49);
        chk(rd_count == 0, "R2 no reads while disabled", rd_count, 0);
        pix(100, 8'h3C, o);
        chk(o == 8'h3C, "R2 pass-through while disabled", o, 8'h3C);

        wr(2'd0, 1);
        // R3/R4: line 50 -> image line 10
        blank(49);
        chk(rd_count == 16, "R3 burst length", rd_count, 16);
        chk(first_addr == BASE_AL + 160, "R3 R4 first address", first_addr, BASE_AL + 160);
        chk(addr_err == 0, "R3 consecutive aligned addresses", addr_err, 0);

        // R5/R6/R7/R9 table walk
        for (int k = 0; k < 12; k++) begin
            logic [7:0] e;
            pix(int'(VEC[k][19:8]), VEC[k][7:0], o);
            e = model(10, int'(VEC[k][19:8]), VEC[k][7:0]);
            chk(o == e, $sformatf("R5 R6 R7 vector %0d", k), o, e);
        end
        // R9 explicit combinations at columns 0..3
        pix(100, 8'h3C, o); chk(o == 8'hC3, "R9 mask1 inv1 inverts", o, 8'hC3);
        pix(101, 8'h3C, o); chk(o == 8'h3C, "R9 mask1 inv0 transparent", o, 8'h3C);
        pix(102, 8'h3C, o); chk(o == 8'hFF, "R9 mask0 inv1 ones", o, 8'hFF);
        pix(103, 8'h3C, o); chk(o == 8'h00, "R9 mask0 inv0 zeros", o, 8'h00);
        // R6: beam_active low passes through
        @(negedge clk); beam_active = 0; beam_x = 102; pix_in = 8'h11;
        @(negedge clk); chk(pix_out == 8'h11, "R6 blanking pass-through", pix_out, 8'h11);

        // R4: line above window, no fetch; R8: no cursor on that line
        blank(38);
        chk(rd_count == 0, "R4 line above window", rd_count, 0);
        pix(102, 8'h3C, o);
        chk(o == 8'h3C, "R8 stale buffer not shown", o, 8'h3C);
        blank(39);
        chk(first_addr == BASE_AL && rd_count == 16, "R4 top image line", first_addr, BASE_AL);
        // last line 63, then below window
        blank(102);
        chk(first_addr == BASE_AL + 1008 && rd_count == 16, "R4 last image line", first_addr, BASE_AL + 1008);
        pix(110, 8'h96, o);
        chk(o == model(63, 110, 8'h96), "R5 last line pixel", o, model(63, 110, 8'h96));
        blank(103);
        chk(rd_count == 0, "R4 line below window", rd_count, 0);
        pix(110, 8'h96, o);
        chk(o == 8'h96, "R8 below window pass-through", o, 8'h96);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule